// File: doc/BRIEF.md
# Writeback Value Aging Buffer

This block sits between the writeback port of an execution pipeline and the architectural register file. Every produced result is first parked in a small ring of slots, tagged with its physical register number, instead of being written to the register file at once. A result reaches the register file only when it ages out of the oldest slot. If its register is released while the result is still parked, the slot is marked dead and the value is dropped without any register-file write. Many short-lived results are therefore never written to the large array.

Reads probe the ring first. On a hit the youngest live copy is returned one cycle after the request and the register file is not touched. On a miss the block issues a register-file read one cycle after the request and returns that data one cycle later. A flush request empties the ring in age order, one slot per cycle, so that the register file ends up holding every live value.

Top module: `vab_top`

## Requirements
- R1: After synchronous reset the ring is empty and `rf_wr_en`, `rf_rd_en`, `rd_valid` and `flush_busy` are all low.
- R2: A writeback (`wb_valid`) into a ring that is not full and not flushing is stored in the ring and causes no register-file write in that cycle or later until the slot ages out.
- R3: A writeback arriving when all DEPTH slots are occupied pops the oldest slot in the same cycle; if that slot is live, `rf_wr_en` is high in that cycle with its tag and data.
- R4: A release (`free_valid`, `free_tag`) marks every parked slot with that tag dead; a dead slot that leaves the ring, by eviction or by flush, produces no register-file write, and this also holds when the release and the pop fall in the same cycle.
- R5: A read (`rd_req`, `rd_tag`) that matches a live slot gives `rd_valid` high with the slot data in the next cycle, and `rf_rd_en` stays low.
- R6: When several live slots carry the read tag, the data of the most recently written one is returned.
- R7: A read with no live match raises `rf_rd_en` with `rf_rd_tag` equal to the read tag in the next cycle, and in the cycle after that raises `rd_valid` with `rd_data` equal to `rf_rd_data`.
- R8: A `flush_req` pulse makes `flush_busy` high from the next cycle until the ring is empty; each busy cycle pops the oldest slot, writing it to the register file only if it is live; a flush of an empty ring leaves `flush_busy` low.
- R9: A read of a tag whose parked copies have all been released is treated as a miss and is served from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | Writeback result present |
| wb_tag | input | 6 | Physical register of the writeback |
| wb_data | input | 32 | Writeback value |
| free_valid | input | 1 | Release of a physical register |
| free_tag | input | 6 | Physical register being released |
| flush_req | input | 1 | Start draining the ring |
| flush_busy | output | 1 | Drain in progress |
| rd_req | input | 1 | Read request |
| rd_tag | input | 6 | Physical register to read |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 32 | Read response value |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_tag | output | 6 | Register-file write address |
| rf_wr_data | output | 32 | Register-file write value |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_tag | output | 6 | Register-file read address |
| rf_rd_data | input | 32 | Register-file read value, valid the cycle after `rf_rd_en` |

## Verification
The assertions take two things for granted about the surroundings: no writeback arrives while `flush_busy` is high, and no new read is issued in a cycle where `rf_rd_en` is high, since otherwise a late miss response and an early hit response would collide. The register file is assumed to return read data exactly one cycle after its strobe. The directed tasks drive one operation at a time, start a read only after the previous response has been seen, and never push during a drain, so every stimulus stays inside those limits.

// File: rtl/vab_pkg.sv
package vab_pkg;

    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;

    // One parked result
    typedef struct packed {
        logic  live;
        tag_t  tag;
        data_t data;
    } slot_t;

    // Source of the response in the first read stage
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_BUF  = 2'd1,
        RSP_RF   = 2'd2
    } rsp_src_t;

    function automatic slot_t make_slot(input tag_t t, input data_t d);
        slot_t s;
        s.live = 1'b1;
        s.tag  = t;
        s.data = d;
        return s;
    endfunction

    function automatic logic slot_matches(input slot_t s, input tag_t t);
        return s.live && (s.tag == t);
    endfunction

endpackage

// File: rtl/vab_store.sv
module vab_store
    import vab_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  tag_t                     push_tag,
    input  data_t                    push_data,
    input  logic                     pop,
    input  logic                     kill_en,
    input  tag_t                     kill_tag,
    output slot_t [DEPTH-1:0]        slots,
    output logic  [PTR_W-1:0]        head,
    output logic  [CNT_W-1:0]        count
);

    generate
        if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
            $error("vab_store: DEPTH must be a power of two and at least 2");
        end
    endgenerate

    logic [PTR_W-1:0] tail;

    // When the ring is full the tail wraps onto the head slot, which is
    // exactly the slot being popped in that cycle.
    assign tail = head + count[PTR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (kill_en && slots[i].tag == kill_tag) begin
                    slots[i].live <= 1'b0;
                end
            end
            if (push) begin
                slots[tail] <= make_slot(push_tag, push_data);
            end
            if (pop) begin
                head <= head + PTR_W'(1);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/vab_lookup.sv
module vab_lookup
    import vab_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  slot_t [DEPTH-1:0]  slots,
    input  logic  [PTR_W-1:0]  head,
    input  logic  [CNT_W-1:0]  count,
    input  tag_t               probe_tag,
    output logic               hit,
    output data_t              hit_data
);

    // Walk from oldest to youngest; a later match overrides an earlier one,
    // so the youngest live copy wins.
    always_comb begin
        logic [PTR_W-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if (CNT_W'(k) < count && slot_matches(slots[idx], probe_tag)) begin
                hit      = 1'b1;
                hit_data = slots[idx].data;
            end
        end
    end

endmodule

// File: rtl/vab_read_pipe.sv
module vab_read_pipe
    import vab_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_req,
    input  tag_t   rd_tag,
    input  logic   buf_hit,
    input  data_t  buf_data,
    output logic   rf_rd_en,
    output tag_t   rf_rd_tag,
    input  data_t  rf_rd_data,
    output logic   rd_valid,
    output data_t  rd_data
);

    rsp_src_t src1_q;
    data_t    data1_q;
    tag_t     tag1_q;
    logic     rf2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src1_q  <= RSP_IDLE;
            data1_q <= '0;
            tag1_q  <= '0;
            rf2_q   <= 1'b0;
        end else begin
            if (!rd_req) begin
                src1_q <= RSP_IDLE;
            end else if (buf_hit) begin
                src1_q <= RSP_BUF;
            end else begin
                src1_q <= RSP_RF;
            end
            data1_q <= buf_data;
            tag1_q  <= rd_tag;
            rf2_q   <= (src1_q == RSP_RF);
        end
    end

    assign rf_rd_en  = (src1_q == RSP_RF);
    assign rf_rd_tag = tag1_q;
    assign rd_valid  = (src1_q == RSP_BUF) || rf2_q;
    assign rd_data   = (src1_q == RSP_BUF) ? data1_q :
                       rf2_q               ? rf_rd_data : '0;

endmodule

// File: rtl/vab_top.sv
module vab_top
    import vab_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wb_valid,
    input  logic [TAG_W-1:0]     wb_tag,
    input  logic [DATA_W-1:0]    wb_data,
    input  logic                 free_valid,
    input  logic [TAG_W-1:0]     free_tag,
    input  logic                 flush_req,
    output logic                 flush_busy,
    input  logic                 rd_req,
    input  logic [TAG_W-1:0]     rd_tag,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rf_wr_en,
    output logic [TAG_W-1:0]     rf_wr_tag,
    output logic [DATA_W-1:0]    rf_wr_data,
    output logic                 rf_rd_en,
    output logic [TAG_W-1:0]     rf_rd_tag,
    input  logic [DATA_W-1:0]    rf_rd_data
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    slot_t [DEPTH-1:0] slots;
    logic  [PTR_W-1:0] head_ptr;
    logic  [CNT_W-1:0] count;
    logic  [CNT_W-1:0] count_nxt;
    slot_t             head_slot;
    logic              ring_full;
    logic              evict;
    logic              drain_pop;
    logic              pop;
    logic              head_freed_now;
    logic              drain_q;
    logic              buf_hit;
    data_t             buf_data;

    assign ring_full      = (count == FULL_CNT);
    assign head_slot      = slots[head_ptr];
    assign evict          = wb_valid && ring_full;
    assign drain_pop      = drain_q && (count != '0);
    assign pop            = evict || drain_pop;
    assign head_freed_now = free_valid && (head_slot.tag == free_tag);
    assign count_nxt      = count + CNT_W'(wb_valid) - CNT_W'(pop);

    // Only a live oldest slot that is not being released right now is written.
    assign rf_wr_en   = pop && head_slot.live && !head_freed_now;
    assign rf_wr_tag  = head_slot.tag;
    assign rf_wr_data = head_slot.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_q <= 1'b0;
        end else begin
            drain_q <= (drain_q || flush_req) && (count_nxt != '0);
        end
    end

    assign flush_busy = drain_q;

    vab_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (wb_valid),
        .push_tag  (wb_tag),
        .push_data (wb_data),
        .pop       (pop),
        .kill_en   (free_valid),
        .kill_tag  (free_tag),
        .slots     (slots),
        .head      (head_ptr),
        .count     (count)
    );

    vab_lookup #(.DEPTH(DEPTH)) u_lookup (
        .slots     (slots),
        .head      (head_ptr),
        .count     (count),
        .probe_tag (rd_tag),
        .hit       (buf_hit),
        .hit_data  (buf_data)
    );

    vab_read_pipe u_read (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .rd_tag     (rd_tag),
        .buf_hit    (buf_hit),
        .buf_data   (buf_data),
        .rf_rd_en   (rf_rd_en),
        .rf_rd_tag  (rf_rd_tag),
        .rf_rd_data (rf_rd_data),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/vab_checker.sv
module vab_checker
    import vab_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wb_valid,
    input logic              free_valid,
    input tag_t              free_tag,
    input logic              flush_busy,
    input logic              rd_req,
    input tag_t              rd_tag,
    input logic              buf_hit,
    input logic              rd_valid,
    input logic              rf_wr_en,
    input tag_t              rf_wr_tag,
    input logic              rf_rd_en,
    input tag_t              rf_rd_tag,
    input logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    a_r2_write_needs_pop: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> ((wb_valid && count == FULL_CNT) || flush_busy));

    a_r3_full_stays_full: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && count == FULL_CNT && !flush_busy) |=> (count == FULL_CNT));

    a_r4_freed_not_written: assert property (@(posedge clk) disable iff (rst)
        (free_valid && rf_wr_en) |-> (rf_wr_tag != free_tag));

    a_r5_hit_skips_rf: assert property (@(posedge clk) disable iff (rst)
        (rd_req && buf_hit) |=> (rd_valid && !rf_rd_en));

    a_r7_miss_requests_rf: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !buf_hit) |=> (rf_rd_en && rf_rd_tag == $past(rd_tag)));

    a_r7_miss_responds: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |=> rd_valid);

    // Input assumption: no new read while a register-file read is in flight
    a_r7_no_read_in_miss: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |-> !rd_req);

    // Input assumption: no writeback during a drain
    a_r8_no_push_in_drain: assert property (@(posedge clk) disable iff (rst)
        flush_busy |-> !wb_valid);

    a_r8_drain_step: assert property (@(posedge clk) disable iff (rst)
        (flush_busy && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    a_r8_drain_ends: assert property (@(posedge clk) disable iff (rst)
        (flush_busy && count == CNT_W'(1)) |=> !flush_busy);

endmodule

bind vab_top vab_checker #(.DEPTH(DEPTH)) u_vab_chk (
    .clk        (clk),
    .rst        (rst),
    .wb_valid   (wb_valid),
    .free_valid (free_valid),
    .free_tag   (free_tag),
    .flush_busy (flush_busy),
    .rd_req     (rd_req),
    .rd_tag     (rd_tag),
    .buf_hit    (buf_hit),
    .rd_valid   (rd_valid),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_tag  (rf_wr_tag),
    .rf_rd_en   (rf_rd_en),
    .rf_rd_tag  (rf_rd_tag),
    .count      (count)
);

// File: tb/vab_top_test.sv
module vab_top_test;
    import vab_pkg::*;

    localparam int DEPTH = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst = 1'b1;
    logic        wb_valid = 1'b0;
    tag_t        wb_tag = '0;
    data_t       wb_data = '0;
    logic        free_valid = 1'b0;
    tag_t        free_tag = '0;
    logic        flush_req = 1'b0;
    logic        flush_busy;
    logic        rd_req = 1'b0;
    tag_t        rd_tag = '0;
    logic        rd_valid;
    data_t       rd_data;
    logic        rf_wr_en;
    tag_t        rf_wr_tag;
    data_t       rf_wr_data;
    logic        rf_rd_en;
    tag_t        rf_rd_tag;
    data_t       rf_rd_data;

    vab_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .free_valid(free_valid), .free_tag(free_tag),
        .flush_req(flush_req), .flush_busy(flush_busy),
        .rd_req(rd_req), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_data(rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_tag(rf_wr_tag), .rf_wr_data(rf_wr_data),
        .rf_rd_en(rf_rd_en), .rf_rd_tag(rf_rd_tag), .rf_rd_data(rf_rd_data)
    );

    // Register-file model: synchronous read, write log
    data_t rf_mem [64];
    tag_t  log_tag [64];
    int    log_n;

    function automatic data_t rf_init(input tag_t t);
        return 32'h5000_0000 | 32'(t);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) rf_mem[i] <= rf_init(tag_t'(i));
            log_n      <= 0;
            rf_rd_data <= '0;
        end else begin
            if (rf_wr_en) begin
                rf_mem[rf_wr_tag] <= rf_wr_data;
                log_tag[log_n[5:0]] <= rf_wr_tag;
                log_n <= log_n + 1;
            end
            if (rf_rd_en) rf_rd_data <= rf_mem[rf_rd_tag];
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic next();
        @(posedge clk);
        #1;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wb_valid = 0; free_valid = 0; flush_req = 0; rd_req = 0;
        repeat (3) next();
        rst = 1'b0;
    endtask

    task automatic push(input tag_t t, input data_t d,
                        output logic en, output tag_t wt, output data_t wd);
        wb_valid = 1'b1; wb_tag = t; wb_data = d;
        mid();
        en = rf_wr_en; wt = rf_wr_tag; wd = rf_wr_data;
        next();
        wb_valid = 1'b0;
    endtask

    task automatic release_tag(input tag_t t);
        free_valid = 1'b1; free_tag = t;
        mid();
        chk("R4", "no write on release", 64'(rf_wr_en), 64'd0);
        next();
        free_valid = 1'b0;
    endtask

    task automatic read_check(input tag_t t, input bit exp_hit,
                              input data_t exp, input string req);
        rd_req = 1'b1; rd_tag = t;
        next();
        rd_req = 1'b0;
        mid();
        if (exp_hit) begin
            chk(req, "hit rd_valid", 64'(rd_valid), 64'd1);
            chk(req, "hit rd_data", 64'(rd_data), 64'(exp));
            chk(req, "hit rf_rd_en low", 64'(rf_rd_en), 64'd0);
            next();
        end else begin
            chk(req, "miss rf_rd_en", 64'(rf_rd_en), 64'd1);
            chk(req, "miss rf_rd_tag", 64'(rf_rd_tag), 64'(t));
            chk(req, "miss no early valid", 64'(rd_valid), 64'd0);
            next();
            mid();
            chk(req, "miss rd_valid", 64'(rd_valid), 64'd1);
            chk(req, "miss rd_data", 64'(rd_data), 64'(exp));
            next();
        end
    endtask

    task automatic t_reset();
        do_reset();
        mid();
        chk("R1", "rf_wr_en", 64'(rf_wr_en), 64'd0);
        chk("R1", "rf_rd_en", 64'(rf_rd_en), 64'd0);
        chk("R1", "rd_valid", 64'(rd_valid), 64'd0);
        chk("R1", "flush_busy", 64'(flush_busy), 64'd0);
        next();
    endtask

    task automatic t_fill_and_evict();
        logic en; tag_t wt; data_t wd;
        do_reset();
        for (int i = 1; i <= DEPTH; i++) begin
            push(tag_t'(i), 32'hA000_0000 + 32'(i), en, wt, wd);
            chk("R2", "no write while filling", 64'(en), 64'd0);
        end
        chk("R2", "write log empty", 64'(log_n), 64'd0);
        read_check(5, 1'b1, 32'hA000_0005, "R5");
        push(20, 32'hB000_0020, en, wt, wd);
        chk("R3", "evict strobe", 64'(en), 64'd1);
        chk("R3", "evict tag", 64'(wt), 64'd1);
        chk("R3", "evict data", 64'(wd), 64'hA000_0001);
        push(21, 32'hB000_0021, en, wt, wd);
        chk("R3", "second evict tag", 64'(wt), 64'd2);
        chk("R3", "log count", 64'(log_n), 64'd2);
        chk("R3", "log order", 64'(log_tag[0]), 64'd1);
        read_check(1, 1'b0, 32'hA000_0001, "R3");
    endtask

    task automatic t_release();
        logic en; tag_t wt; data_t wd;
        do_reset();
        for (int i = 1; i <= DEPTH; i++) push(tag_t'(i), 32'hC000_0000 + 32'(i), en, wt, wd);
        release_tag(1);
        push(9, 32'hC000_0009, en, wt, wd);
        chk("R4", "dead slot evicted silently", 64'(en), 64'd0);
        push(10, 32'hC000_000A, en, wt, wd);
        chk("R4", "live slot evicted", 64'(en), 64'd1);
        chk("R4", "live slot tag", 64'(wt), 64'd2);
        // release of the head in the same cycle as its eviction
        wb_valid = 1'b1; wb_tag = 11; wb_data = 32'hC000_000B;
        free_valid = 1'b1; free_tag = 3;
        mid();
        chk("R4", "same-cycle release suppresses", 64'(rf_wr_en), 64'd0);
        next();
        wb_valid = 1'b0; free_valid = 1'b0;
        release_tag(4);
        read_check(4, 1'b0, rf_init(4), "R9");
        push(12, 32'hC000_000C, en, wt, wd);
        chk("R4", "released slot evicted silently", 64'(en), 64'd0);
        chk("R4", "log count", 64'(log_n), 64'd1);
    endtask

    task automatic t_youngest();
        logic en; tag_t wt; data_t wd;
        do_reset();
        push(7, 32'hD000_0001, en, wt, wd);
        push(9, 32'hD000_0009, en, wt, wd);
        push(7, 32'hD000_0002, en, wt, wd);
        read_check(7, 1'b1, 32'hD000_0002, "R6");
        read_check(9, 1'b1, 32'hD000_0009, "R5");
        release_tag(7);
        read_check(7, 1'b0, rf_init(7), "R9");
    endtask

    task automatic t_miss();
        do_reset();
        read_check(30, 1'b0, rf_init(30), "R7");
        read_check(0, 1'b0, rf_init(0), "R7");
    endtask

    task automatic t_flush();
        logic en; tag_t wt; data_t wd;
        tag_t exp_tags [4];
        bit   exp_wr [4];
        exp_tags = '{11, 12, 13, 14};
        exp_wr   = '{1'b1, 1'b0, 1'b1, 1'b1};
        do_reset();
        for (int i = 0; i < 4; i++) push(exp_tags[i], 32'hE000_0000 + 32'(exp_tags[i]), en, wt, wd);
        release_tag(12);
        flush_req = 1'b1;
        mid();
        chk("R8", "busy not yet", 64'(flush_busy), 64'd0);
        next();
        flush_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            mid();
            chk("R8", "busy during drain", 64'(flush_busy), 64'd1);
            chk("R8", "drain write strobe", 64'(rf_wr_en), 64'(exp_wr[i]));
            if (exp_wr[i]) chk("R8", "drain order", 64'(rf_wr_tag), 64'(exp_tags[i]));
            next();
        end
        mid();
        chk("R8", "busy ends when empty", 64'(flush_busy), 64'd0);
        chk("R8", "no write after drain", 64'(rf_wr_en), 64'd0);
        next();
        read_check(13, 1'b0, 32'hE000_000D, "R8");
        read_check(12, 1'b0, rf_init(12), "R4");
        flush_req = 1'b1;
        next();
        flush_req = 1'b0;
        mid();
        chk("R8", "empty flush stays idle", 64'(flush_busy), 64'd0);
        next();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fill_and_evict();
                t_release();
                t_youngest();
                t_miss();
                t_flush();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule